// File: doc/BRIEF.md
# Suspend-Resume Bus Arbiter for Shared Serial Memory

This block shares one serial-memory bus between two masters. The cache port issues short reads that must be served quickly. The maintenance port runs long program or erase operations. When no long operation is in progress, a cache read gets the bus directly. When a cache read arrives while a long operation is running, the arbiter pulses a suspend strobe toward the memory. It then keeps both grants low for a fixed recovery time before it grants the bus to the cache port.

After its transfer, the cache port keeps the bus through a short hold window. Any new cache access during that window is served at once, and the window restarts when that access completes. When the window runs out, the arbiter pulses a resume strobe and waits one recovery time with no grant. It then returns the bus to the maintenance port for a protected interval, during which cache requests cannot suspend the operation again. This interval guarantees that the resumed operation makes progress between suspends. The maintenance completion flag is passed on only while the maintenance port holds the bus.

Top module: `susp_arb`

## Requirements
- R1: With no long operation in progress, a cache request is granted on the next cycle with no suspend strobe. The grant drops on the cycle after `cache_done_i`, with no hold window.
- R2: In the idle state, a maintenance request is granted on the next cycle. When both ports request in the same idle cycle, the cache port wins.
- R3: A cache request while the maintenance port holds the bus produces a suspend strobe on the next cycle, and both grants are low in that cycle.
- R4: The cache grant rises exactly `TSUS_CYC` cycles after the cycle of the suspend strobe. No grant is high before then.
- R5: After `cache_done_i` in a suspended session, the cache grant stays high for `LOCK_CYC` more cycles while no new cache request arrives.
- R6: A cache request during the hold window is served immediately. The hold window counts again from zero when that transfer's `cache_done_i` arrives.
- R7: When the hold window expires, a resume strobe is raised for one cycle and both grants stay low for `TSUS_CYC` cycles. After that, the maintenance grant rises.
- R8: After the maintenance grant returns, it is held for `GUARD_CYC` cycles during which cache requests raise no suspend. The next suspend comes at least `TSUS_CYC + GUARD_CYC` cycles after the resume strobe.
- R9: `maint_done_o` goes high one cycle after `op_done_i` only when the maintenance port holds the bus, and the arbiter then returns to idle. `op_done_i` during a suspend has no effect on `maint_done_o`.
- R10: The two grants are never high together. The suspend and resume strobes each last exactly one cycle.
- R11: While `rst_ni` is low, all grants and strobes are low. After release, the arbiter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| maint_req_i | input | 1 | Maintenance port requests the bus for a long operation |
| op_done_i | input | 1 | Long operation finished |
| maint_gnt_o | output | 1 | Bus granted to the maintenance port |
| maint_done_o | output | 1 | Long operation completion, registered |
| cache_req_i | input | 1 | Cache port read request, level |
| cache_done_i | input | 1 | Cache transfer complete, one-cycle pulse |
| cache_gnt_o | output | 1 | Bus granted to the cache port |
| suspend_o | output | 1 | Suspend command strobe |
| resume_o | output | 1 | Resume command strobe |

## Verification
The grants are decoded straight from the state register. A wrong next state therefore shows at the ports one cycle after the decision, as a grant that is missing or present where it should not be. A counter error does not change which outputs move. Instead, it shifts the grant or resume edge by one or more cycles relative to the suspend or resume strobe, so every timed window is checked to the exact cycle. A lock-restart fault shows as a resume strobe that comes too early after a follow-on cache transfer.

// File: rtl/susp_arb_pkg.sv
package susp_arb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_MAINT     = 3'd1,
    ST_SUSPEND   = 3'd2,
    ST_CACHE     = 3'd3,
    ST_HOLD      = 3'd4,
    ST_RESUME    = 3'd5,
    ST_GUARD     = 3'd6,
    ST_DIRECT    = 3'd7
  } arb_state_e;
endpackage

// File: rtl/susp_arb_timer.sv
module susp_arb_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (cnt_q != limit_i) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/susp_arb_fsm.sv
module susp_arb_fsm
  import susp_arb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       maint_req_i,
  input  logic       op_done_i,
  input  logic       cache_req_i,
  input  logic       cache_done_i,
  input  logic       hit_i,
  output arb_state_e state_o,
  output arb_state_e next_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cache_req_i)      state_d = ST_DIRECT;  // cache wins a tie
        else if (maint_req_i) state_d = ST_MAINT;
      end
      ST_MAINT: begin
        if (op_done_i)        state_d = ST_IDLE;
        else if (cache_req_i) state_d = ST_SUSPEND;
      end
      ST_SUSPEND: if (hit_i) state_d = ST_CACHE;
      ST_CACHE:   if (cache_done_i) state_d = ST_HOLD;
      ST_HOLD: begin
        if (cache_req_i) state_d = ST_CACHE;
        else if (hit_i)  state_d = ST_RESUME;
      end
      ST_RESUME: if (hit_i) state_d = ST_GUARD;
      ST_GUARD: begin
        // resumed op must progress: no suspend honoured here
        if (op_done_i)  state_d = ST_IDLE;
        else if (hit_i) state_d = ST_MAINT;
      end
      ST_DIRECT: if (cache_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign next_o  = state_d;
endmodule

// File: rtl/susp_arb.sv
module susp_arb
  import susp_arb_pkg::*;
#(
  parameter int unsigned TSUS_CYC  = 2000,
  parameter int unsigned LOCK_CYC  = 64,
  parameter int unsigned GUARD_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic maint_req_i,
  input  logic op_done_i,
  output logic maint_gnt_o,
  output logic maint_done_o,
  input  logic cache_req_i,
  input  logic cache_done_i,
  output logic cache_gnt_o,
  output logic suspend_o,
  output logic resume_o
);
  localparam int unsigned MAX_A   = (TSUS_CYC > LOCK_CYC) ? TSUS_CYC : LOCK_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > GUARD_CYC) ? MAX_A : GUARD_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] TSUS_LIM  = CNT_W'(TSUS_CYC - 1);
  localparam logic [CNT_W-1:0] LOCK_LIM  = CNT_W'(LOCK_CYC - 1);
  localparam logic [CNT_W-1:0] GUARD_LIM = CNT_W'(GUARD_CYC - 1);

  arb_state_e       state_q, state_d;
  logic             hit;
  logic [CNT_W-1:0] limit;

  susp_arb_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .maint_req_i  (maint_req_i),
    .op_done_i    (op_done_i),
    .cache_req_i  (cache_req_i),
    .cache_done_i (cache_done_i),
    .hit_i        (hit),
    .state_o      (state_q),
    .next_o       (state_d)
  );

  always_comb begin
    unique case (state_q)
      ST_HOLD:  limit = LOCK_LIM;
      ST_GUARD: limit = GUARD_LIM;
      default:  limit = TSUS_LIM;
    endcase
  end

  susp_arb_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_d != state_q),
    .limit_i (limit),
    .hit_o   (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      suspend_o    <= 1'b0;
      resume_o     <= 1'b0;
      maint_done_o <= 1'b0;
    end else begin
      suspend_o    <= (state_q == ST_MAINT) && (state_d == ST_SUSPEND);
      resume_o     <= (state_q == ST_HOLD)  && (state_d == ST_RESUME);
      maint_done_o <= op_done_i && ((state_q == ST_MAINT) || (state_q == ST_GUARD));
    end
  end

  assign maint_gnt_o = (state_q == ST_MAINT) || (state_q == ST_GUARD);
  assign cache_gnt_o = (state_q == ST_CACHE) || (state_q == ST_HOLD) ||
                       (state_q == ST_DIRECT);
endmodule

// File: rtl/susp_arb_chk.sv
module susp_arb_chk #(
  parameter int unsigned TSUS_CYC  = 2000,
  parameter int unsigned GUARD_CYC = 2000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic maint_gnt_o,
  input logic maint_done_o,
  input logic cache_gnt_o,
  input logic suspend_o,
  input logic resume_o
);
  logic [31:0] sus_age, res_age;
  logic        in_susp, res_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sus_age  <= '0;
      res_age  <= '0;
      in_susp  <= 1'b0;
      res_seen <= 1'b0;
    end else begin
      if (suspend_o)             sus_age <= 32'd1;
      else if (sus_age != '1)    sus_age <= sus_age + 1'b1;
      if (resume_o)              res_age <= 32'd1;
      else if (res_age != '1)    res_age <= res_age + 1'b1;
      if (suspend_o)             in_susp <= 1'b1;
      else if (resume_o)         in_susp <= 1'b0;
      if (resume_o)              res_seen <= 1'b1;
    end
  end

  assert_one_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(maint_gnt_o && cache_gnt_o));
  assert_susp_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |=> !suspend_o);
  assert_res_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |=> !resume_o);
  assert_susp_from_maint_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_o |-> ($past(maint_gnt_o) && !maint_gnt_o && !cache_gnt_o));
  assert_tsus_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cache_gnt_o) && in_susp) |-> (sus_age >= TSUS_CYC));
  assert_res_from_cache_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_o |-> ($past(cache_gnt_o) && !cache_gnt_o && !maint_gnt_o));
  assert_guard_gap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (suspend_o && res_seen) |-> (res_age >= TSUS_CYC + GUARD_CYC));
  assert_done_owner_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maint_done_o |-> $past(maint_gnt_o));
endmodule

bind susp_arb susp_arb_chk #(.TSUS_CYC(TSUS_CYC), .GUARD_CYC(GUARD_CYC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .maint_gnt_o  (maint_gnt_o),
  .maint_done_o (maint_done_o),
  .cache_gnt_o  (cache_gnt_o),
  .suspend_o    (suspend_o),
  .resume_o     (resume_o)
);

// File: tb/susp_arb_bench.sv
`timescale 1ns/1ps
module susp_arb_bench;
  localparam int unsigned TSUS  = 3;
  localparam int unsigned LOCK  = 2;
  localparam int unsigned GUARD = 2;
  localparam int NROW = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreq = 0, opdone = 0, creq = 0, cdone = 0;
  logic mgnt, mdone, cgnt, sus, res;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  susp_arb #(.TSUS_CYC(TSUS), .LOCK_CYC(LOCK), .GUARD_CYC(GUARD)) u_susp_arb (
    .clk_i(clk), .rst_ni(rst_n),
    .maint_req_i(mreq), .op_done_i(opdone), .maint_gnt_o(mgnt), .maint_done_o(mdone),
    .cache_req_i(creq), .cache_done_i(cdone), .cache_gnt_o(cgnt),
    .suspend_o(sus), .resume_o(res)
  );

  // {req#, mreq, opdone, creq, cdone, exp mgnt, cgnt, sus, res, mdone}
  typedef logic [12:0] row_t;
  localparam row_t VEC [NROW] = '{
    {4'd2,  4'b1000, 5'b10000},  // R2 maint granted
    {4'd3,  4'b0010, 5'b00100},  // R3 suspend strobe
    {4'd4,  4'b0010, 5'b00000},  // R4 waiting
    {4'd4,  4'b0010, 5'b00000},  // R4 waiting
    {4'd4,  4'b0010, 5'b01000},  // R4 cache grant after TSUS
    {4'd5,  4'b0001, 5'b01000},  // R5 hold
    {4'd5,  4'b0000, 5'b01000},  // R5 hold
    {4'd6,  4'b0010, 5'b01000},  // R6 new access in hold
    {4'd6,  4'b0001, 5'b01000},  // R6 hold restarts
    {4'd6,  4'b0000, 5'b01000},  // R6 still held
    {4'd7,  4'b0000, 5'b00010},  // R7 resume strobe
    {4'd7,  4'b0000, 5'b00000},  // R7 recovery
    {4'd7,  4'b0010, 5'b00000},  // R7 recovery, request waits
    {4'd8,  4'b0010, 5'b10000},  // R8 guard
    {4'd8,  4'b0010, 5'b10000},  // R8 guard
    {4'd8,  4'b0010, 5'b10000},  // R8 back to busy
    {4'd8,  4'b0010, 5'b00100},  // R8 suspend only now
    {4'd9,  4'b0110, 5'b00000},  // R9 done while suspended ignored
    {4'd4,  4'b0010, 5'b00000},  // R4
    {4'd4,  4'b0010, 5'b01000},  // R4
    {4'd5,  4'b0001, 5'b01000},  // R5
    {4'd5,  4'b0000, 5'b01000},  // R5
    {4'd7,  4'b0000, 5'b00010},  // R7
    {4'd7,  4'b0000, 5'b00000},  // R7
    {4'd7,  4'b0000, 5'b00000},  // R7
    {4'd7,  4'b0000, 5'b10000},  // R7 maint back
    {4'd9,  4'b0100, 5'b00001},  // R9 done reported
    {4'd1,  4'b0010, 5'b01000},  // R1 direct grant
    {4'd1,  4'b0001, 5'b00000},  // R1 no hold window
    {4'd2,  4'b1010, 5'b01000},  // R2 cache wins tie
    {4'd2,  4'b1001, 5'b00000},  // R2
    {4'd2,  4'b1000, 5'b10000},  // R2
    {4'd9,  4'b0100, 5'b00001}   // R9
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v);
    {mreq, opdone, creq, cdone} = v;
  endtask

  function automatic logic [4:0] outs();
    return {mgnt, cgnt, sus, res, mdone};
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic prev_sus;
    #5;
    check("R11 in reset", outs(), 5'b00000);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", outs(), 5'b00000);
    prev_sus = 1'b0;
    for (int i = 0; i < NROW; i++) begin
      drive(VEC[i][8:5]);
      @(negedge clk);
      check($sformatf("R%0d row %0d", VEC[i][12:9], i), outs(), VEC[i][4:0]);
      check("R10 single grant", {4'b0, mgnt & cgnt}, 5'b0);
      check("R10 strobe width", {4'b0, prev_sus & sus}, 5'b0);
      prev_sus = sus;
    end
    drive(4'b0000);
    // R11: reset mid operation
    drive(4'b1000);
    @(negedge clk);
    drive(4'b0010);
    @(negedge clk);
    check("R11 suspend before reset", outs(), 5'b00100);
    rst_n = 1'b0;
    #1;
    check("R11 async reset clears", outs(), 5'b00000);
    drive(4'b0000);
    @(negedge clk);
    rst_n = 1'b1;
    drive(4'b0010);
    @(negedge clk);
    check("R11 R1 direct grant after reset", outs(), 5'b01000);
    drive(4'b0001);
    @(negedge clk);
    check("R1 release", outs(), 5'b00000);
    drive(4'b0000);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule